// File: doc/BRIEF.md
# Programmable Interval Prescaler Timer

This block is an interval timer built around a 14-stage binary divider. The divider advances either on every system clock cycle or once for each pulse of a slow sub-clock enable, as chosen by a clock-select bit. A 3-bit interval field picks one of eight divider stages as the timer source. That source is registered onto the system clock to form the timer output, which other peripherals use as a prescaler clock. Each rising edge of the source also raises a single-cycle interrupt pulse. A second 2-bit field picks another divider stage, which is brought out as the clock for an external watchdog counter.

The timer begins counting as soon as reset is released; software does not need to start it. Software can restart it with a control write that carries the restart bit, but that request only takes effect while the watchdog is switched off. In sleep the output is held low, while the divider keeps counting and interrupts are still raised. A bypass bit routes the sub-clock pulse directly to the output and interrupt logic, skipping the divider.

Top module: `ivt_timer`

## Requirements
- R1: With clock-select (control-2 bit 0) at 1 the divider counts up by one on every clock cycle. With it at 0 the divider counts up only in cycles where `sub_tick` is high. In all other cycles it holds its value.
- R2: Reset clears the divider and loads these defaults: interval 0, sub-clock selected, bypass off, interrupt masked (control-2 bit 2 set), watchdog tap 0. The divider counts from the first cycle after reset, with no write needed.
- R3: The interval field is control-1 bits 2:0. A value n selects divider bit b(n): b(0)=0, and b(n)=2n-1 for n from 1 to 7. This gives bits 0,1,3,5,7,9,11,13.
- R4: When unmasked, `tmr_irq` is high for exactly one cycle, one register stage after each rising edge of the selected source. While the divider counts on every clock, the interrupts are therefore 2^(b+1) cycles apart.
- R5: While the mask bit (control-2 bit 2) is 1, `tmr_irq` stays low.
- R6: A control-1 write with the restart bit (bit 3) set, while `wdt_on` is low, clears the divider. Counting on every clock, the first interrupt then appears 2^b+1 cycles after the write edge.
- R7: A restart write while `wdt_on` is high leaves the divider count unchanged, so counting continues. The interval field of that write is still stored.
- R8: While `sleep` is high, `tmr_out` is 0 from the next cycle on. The divider keeps counting and `tmr_irq` pulses are still produced.
- R9: With bypass (control-2 bit 1) at 1, `sub_tick` replaces the divider stage as the selected source. `tmr_out` and `tmr_irq` then follow a `sub_tick` pulse one cycle later.
- R10: The watchdog tap field is control-2 bits 4:3. A value m drives `wdt_clk` directly from divider bit 10+m.
- R11: Outside sleep, `tmr_out` equals the selected source delayed by one clock cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sub_tick | input | 1 | Sub-clock enable pulse, synchronous to clk |
| sleep | input | 1 | Sleep state; forces the output low |
| wdt_on | input | 1 | Watchdog active; blocks restart |
| ctl1_we | input | 1 | Write strobe for control register 1 |
| ctl1_wdata | input | 4 | {restart, interval[2:0]} |
| ctl2_we | input | 1 | Write strobe for control register 2 |
| ctl2_wdata | input | 5 | {wdt_tap[1:0], mask, bypass, clk_sel} |
| tmr_out | output | 1 | Synchronised timer / prescaler output |
| tmr_irq | output | 1 | Single-cycle interrupt pulse |
| wdt_clk | output | 1 | Divider tap feeding the watchdog |

## Verification
The assertions assume that `sub_tick` and every control input are synchronous to `clk` and stable around its rising edge. They also assume the block stays clocked during sleep, which is how sleep is modelled here. The stimulus changes every input only on the falling clock edge and holds the write strobes for exactly one cycle. It keeps `sub_tick` low when the system clock is selected, so the bypass and sub-clock cases do not mix with system-rate counting. Timing checks are made only after an accepted restart, so each expected cycle count starts from a known divider value of zero.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int DIV_W    = 14;
  localparam int IVL_W    = 3;
  localparam int WSEL_W   = 2;
  localparam int WDT_BASE = 10;

  typedef struct packed {
    logic [IVL_W-1:0]  interval;
    logic              clk_sel;
    logic              bypass;
    logic              mask;
    logic [WSEL_W-1:0] wdt_sel;
  } ivt_cfg_t;

  // divider bit used as timer source for a given interval code
  function automatic int unsigned tap_bit(input logic [IVL_W-1:0] code);
    int unsigned n;
    n = int'(code);
    return (n == 0) ? 0 : (2 * n - 1);
  endfunction

  // divider bit feeding the watchdog clock
  function automatic int unsigned wdt_bit(input logic [WSEL_W-1:0] code);
    return WDT_BASE + int'(code);
  endfunction
endpackage

// File: rtl/ivt_ctrl_regs.sv
module ivt_ctrl_regs
  import ivt_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wdt_on,
  input  logic                   ctl1_we,
  input  logic [IVL_W:0]         ctl1_wdata,
  input  logic                   ctl2_we,
  input  logic [WSEL_W+2:0]      ctl2_wdata,
  output ivt_cfg_t               cfg,
  output logic                   restart_ok
);
  localparam int RST_BIT = IVL_W;

  logic restart_req;
  assign restart_req = ctl1_we && ctl1_wdata[RST_BIT];
  assign restart_ok  = restart_req && !wdt_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg.interval <= '0;
      cfg.clk_sel  <= 1'b0;
      cfg.bypass   <= 1'b0;
      cfg.mask     <= 1'b1;
      cfg.wdt_sel  <= '0;
    end else begin
      if (ctl1_we) cfg.interval <= ctl1_wdata[IVL_W-1:0];
      if (ctl2_we) begin
        cfg.clk_sel <= ctl2_wdata[0];
        cfg.bypass  <= ctl2_wdata[1];
        cfg.mask    <= ctl2_wdata[2];
        cfg.wdt_sel <= ctl2_wdata[WSEL_W+2:3];
      end
    end
  end

  // R7
  restart_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_on && restart_req) |-> !restart_ok);
endmodule

// File: rtl/ivt_divider.sv
module ivt_divider
  import ivt_pkg::*;
#(
  parameter int W = DIV_W
)(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  input  logic         clr,
  output logic [W-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else if (adv) count <= count + W'(1);
  end

  // R1
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !adv) |=> $stable(count));
endmodule

// File: rtl/ivt_tap_sync.sv
module ivt_tap_sync
  import ivt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] count,
  input  ivt_cfg_t         cfg,
  input  logic             sub_tick,
  input  logic             sleep,
  output logic             src,
  output logic             tmr_out,
  output logic             tmr_irq,
  output logic             wdt_clk
);
  logic src_q;
  logic src_rise;

  always_comb begin
    if (cfg.bypass) src = sub_tick;
    else            src = count[tap_bit(cfg.interval)];
    wdt_clk = count[wdt_bit(cfg.wdt_sel)];
  end

  assign src_rise = src && !src_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q   <= 1'b0;
      tmr_out <= 1'b0;
      tmr_irq <= 1'b0;
    end else begin
      src_q   <= src;
      tmr_out <= src && !sleep;
      tmr_irq <= src_rise && !cfg.mask;
    end
  end

  // R4
  irq_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_irq |=> !tmr_irq);
  // R5
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg.mask) |-> !tmr_irq);
  // R8
  sleep_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> !tmr_out);
  // R11
  irq_with_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_irq && !$past(sleep)) |-> tmr_out);
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sub_tick,
  input  logic              sleep,
  input  logic              wdt_on,
  input  logic              ctl1_we,
  input  logic [IVL_W:0]    ctl1_wdata,
  input  logic              ctl2_we,
  input  logic [WSEL_W+2:0] ctl2_wdata,
  output logic              tmr_out,
  output logic              tmr_irq,
  output logic              wdt_clk
);
  ivt_cfg_t         cfg;
  logic             restart_ok;
  logic             adv;
  logic [DIV_W-1:0] count;
  logic             src;

  assign adv = cfg.clk_sel ? 1'b1 : sub_tick;

  ivt_ctrl_regs u_regs (
    .clk, .rst_n, .wdt_on, .ctl1_we, .ctl1_wdata, .ctl2_we, .ctl2_wdata,
    .cfg, .restart_ok
  );

  ivt_divider #(.W(DIV_W)) u_div (
    .clk, .rst_n, .adv, .clr(restart_ok), .count
  );

  ivt_tap_sync u_tap (
    .clk, .rst_n, .count, .cfg, .sub_tick, .sleep,
    .src, .tmr_out, .tmr_irq, .wdt_clk
  );

  // R6
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl1_we && ctl1_wdata[IVL_W] && !wdt_on) |=> (count == '0));
  // R7
  restart_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl1_we && ctl1_wdata[IVL_W] && wdt_on) |=>
      (count == DIV_W'($past(count) + DIV_W'($past(adv)))));
  // R1
  sys_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg.clk_sel && !restart_ok) |=> (count == DIV_W'($past(count) + DIV_W'(1))));
endmodule

// File: tb/ivt_timer_tb_top.sv
module ivt_timer_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sub_tick = 1'b0, sleep = 1'b0, wdt_on = 1'b0;
  logic ctl1_we = 1'b0, ctl2_we = 1'b0;
  logic [3:0] ctl1_wdata = '0;
  logic [4:0] ctl2_wdata = '0;
  logic tmr_out, tmr_irq, wdt_clk;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  // interval code -> first-interrupt latency and interrupt spacing (R3, R4, R6)
  localparam int unsigned LAT [8] = '{2, 3, 9, 33, 129, 513, 2049, 8193};
  localparam int unsigned PER [8] = '{2, 4, 16, 64, 256, 1024, 4096, 16384};

  always #10 clk = ~clk;

  ivt_timer dut_i (
    .clk, .rst_n, .sub_tick, .sleep, .wdt_on, .ctl1_we, .ctl1_wdata,
    .ctl2_we, .ctl2_wdata, .tmr_out, .tmr_irq, .wdt_clk
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr1(input logic [3:0] d);
    @(negedge clk); ctl1_we = 1'b1; ctl1_wdata = d;
    @(negedge clk); ctl1_we = 1'b0;
  endtask

  task automatic wr2(input logic [4:0] d);
    @(negedge clk); ctl2_we = 1'b1; ctl2_wdata = d;
    @(negedge clk); ctl2_we = 1'b0;
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tmr_irq && n < 40000);
  endtask

  initial begin
    int n;
    int pulses;
    repeat (3) @(negedge clk);
    // R2 reset state
    check("R2 out", int'(tmr_out), 0);
    check("R2 irq", int'(tmr_irq), 0);
    check("R2 wdt", int'(wdt_clk), 0);
    rst_n = 1'b1;
    // R2/R1: sub-clock default, runs without any write
    repeat (5) @(negedge clk);
    check("R1 hold without sub_tick", int'(tmr_out), 0);
    sub_tick = 1'b1;
    @(negedge clk); sub_tick = 1'b0;
    @(negedge clk);
    check("R2 auto start out", int'(tmr_out), 1);
    check("R2 masked irq", int'(tmr_irq), 0);
    repeat (20) @(negedge clk);
    check("R1 held value", int'(tmr_out), 1);

    // system clock, unmasked, tap 0 for watchdog
    wr2(5'b00_0_0_1);
    for (int i = 0; i < 8; i++) begin
      wr1(4'b1000 | 4'(i));
      wait_irq(n);
      check($sformatf("R6 latency code %0d", i), n, int'(LAT[i]));
      wait_irq(n);
      check($sformatf("R4 period code %0d (R3)", i), n, int'(PER[i]));
    end

    // R7: restart ignored while watchdog on
    wr1(4'b1101);
    wait_irq(n);
    check("R6 latency code 5", n, 513);
    wdt_on = 1'b1;
    wr1(4'b1101);
    wdt_on = 1'b0;
    wait_irq(n);
    check("R7 ignored restart", n, 1022);

    // R10: watchdog tap 2 -> bit 12
    wr2(5'b10_0_0_1);
    wr1(4'b1000);
    n = 0;
    do begin @(negedge clk); n++; end while (!wdt_clk && n < 10000);
    check("R10 wdt tap rise", n, 4096);

    // R5: masked
    wr2(5'b00_1_0_1);
    pulses = 0;
    repeat (100) begin @(negedge clk); if (tmr_irq) pulses++; end
    check("R5 masked pulses", pulses, 0);

    // R8: sleep keeps output low, irq continues
    wr2(5'b00_0_0_1);
    wr1(4'b1000);
    sleep = 1'b1;
    @(negedge clk);
    pulses = 0; n = 0;
    repeat (40) begin
      @(negedge clk);
      if (tmr_irq) pulses++;
      if (tmr_out) n++;
    end
    check("R8 out high count", n, 0);
    check("R8 irq pulses", pulses, 20);
    sleep = 1'b0;

    // R9/R11: bypass with sub-clock selected
    wr2(5'b00_0_1_0);
    repeat (3) @(negedge clk);
    check("R9 idle out", int'(tmr_out), 0);
    sub_tick = 1'b1;
    @(negedge clk); sub_tick = 1'b0;
    check("R11 out follows", int'(tmr_out), 1);
    check("R9 irq", int'(tmr_irq), 1);
    @(negedge clk);
    check("R9 out falls", int'(tmr_out), 0);
    check("R4 one-cycle irq", int'(tmr_irq), 0);

    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 200000) begin @(posedge clk); cyc++; end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule